// File: doc/BRIEF.md
# DAC Startup and Self-Calibration Sequencer

This controller sits on the host side of an external precision DAC. It takes the converter from power-up to a calibrated, ready state. After a start request it waits for the converter's oscillator to settle. If configured, it then asks a separate serial driver to send the reset clock pattern. Only after that does it touch the register port. It runs a fixed number of self-calibration passes. Each pass writes the command register with the mode field set to self-calibration. Completion is found either by polling the mode field until it reads back as normal mode, or by waiting out the longest possible calibration time. After each pass the controller reads the offset and full-scale results. When all passes are done, it writes the floor averages of both back to the converter.

The register port is abstract. The controller holds `reg_req` with a stable address, direction and write data until the target pulses `reg_ack` for one cycle. Read data is sampled in the acknowledge cycle. Register addresses are 0 for the command register, 1 for the offset result and 2 for the full-scale result. The number of passes is `1 << RUNS_LOG2`. Every wait is a cycle count derived from `CLK_KHZ`: the oscillator wait is `OSC_CYC = CLK_KHZ*OSC_MS` and the calibration limit is `TMO_CYC = CLK_KHZ*CAL_MS`.

States: `ST_IDLE`, `ST_OSC`, `ST_RSTPAT`, `ST_CMD_WR`, `ST_GAP`, `ST_POLL_RD`, `ST_RD_OFS`, `ST_RD_GAIN`, `ST_WR_OFS`, `ST_WR_GAIN`, `ST_READY`, `ST_FAULT`. The transitions are:

- From idle, ready or fault, a start request goes to osc.
- Osc goes to rstpat, or straight to cmd_wr, when the oscillator count ends.
- Rstpat goes to cmd_wr on the pattern acknowledge.
- Cmd_wr goes to gap on acknowledge.
- Gap goes to poll_rd when a poll interval ends.
- Gap goes to rd_ofs when the calibration limit ends in timed mode, and to fault when it ends in polled mode.
- Poll_rd goes to rd_ofs when the mode field reads normal. Otherwise it goes back to gap, or to fault if the limit has already passed.
- Rd_ofs goes to rd_gain.
- Rd_gain goes to cmd_wr when more passes remain, and to wr_ofs after the last pass.
- Wr_ofs goes to wr_gain, and wr_gain goes to ready.

Top module: `dac_cal_seq`

## Requirements
- R1: After reset, `ready`, `busy`, `error`, `reg_req` and `rstpat_req` are all low.
- R2: After a start is accepted, neither `reg_req` nor `rstpat_req` rises until at least `OSC_CYC` cycles have passed.
- R3: With `cfg_do_reset` set, `rstpat_req` rises once, after the oscillator wait and before any register access, and holds until `rstpat_ack`. With it clear, `rstpat_req` never rises.
- R4: Every calibration pass begins with a write to address 0. The write data has bits [1:0] = 2'b01 (self-calibration mode), bit 2 = `cfg_keep_out` (output kept connected), and all other bits zero.
- R5: In polled mode (`cfg_use_poll` = 1), address 0 is read every `POLL_GAP` idle cycles. A pass ends at the first read whose bits [1:0] are 2'b00.
- R6: In timed mode, the next register access after a command write acknowledge comes at least `TMO_CYC` cycles later.
- R7: In polled mode, if `TMO_CYC` cycles pass after the command write without completion, `error` rises, `busy` falls, and no further request is issued.
- R8: After each pass, address 1 is read and then address 2. There are `1 << RUNS_LOG2` passes in total.
- R9: The floor average of the offset results, taken as two's complement, is written to address 1. The floor average of the full-scale results, taken as unsigned, is then written to address 2.
- R10: `busy` is high from the accepted start until `ready` or `error`. `ready` rises only after the final write to address 2 is acknowledged, and stays high until the next start.
- R11: A start request while `busy` is high is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, accepted when not busy |
| cfg_do_reset | input | 1 | Send the reset clock pattern after the oscillator wait |
| cfg_use_poll | input | 1 | 1: poll the mode field; 0: wait the fixed limit |
| cfg_keep_out | input | 1 | Output-connected bit placed in the command write |
| rstpat_req | output | 1 | Request to the serial driver to send the reset pattern |
| rstpat_ack | input | 1 | Reset pattern sent |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 2 | 0 command, 1 offset result, 2 full-scale result |
| reg_wdata | output | DATA_W | Write data |
| reg_ack | input | 1 | One-cycle access acknowledge |
| reg_rdata | input | DATA_W | Read data, valid with `reg_ack` |
| ready | output | 1 | Calibrated and averaged values written |
| busy | output | 1 | Sequence in progress |
| error | output | 1 | Polled calibration exceeded the limit |

## Verification
Two events can meet in one cycle: a new start request, and a register acknowledge that moves the sequence forward. The bench raises `start` in the very cycle the offset read of the second pass is acknowledged. The scoreboard then checks that the remaining transaction order is unchanged: no return to the oscillator wait, and no second reset pattern. A second overlap is a poll acknowledge arriving near the calibration limit. In that case a never-finishing converter must end in `error`, and nothing may be written afterwards.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OSC,
        ST_RSTPAT,
        ST_CMD_WR,
        ST_GAP,
        ST_POLL_RD,
        ST_RD_OFS,
        ST_RD_GAIN,
        ST_WR_OFS,
        ST_WR_GAIN,
        ST_READY,
        ST_FAULT
    } seq_state_e;

    localparam logic [1:0] RA_CMD  = 2'd0;
    localparam logic [1:0] RA_OFS  = 2'd1;
    localparam logic [1:0] RA_GAIN = 2'd2;

    localparam logic [1:0] MODE_SELFCAL = 2'b01;
    localparam logic [1:0] MODE_NORMAL  = 2'b00;

endpackage

// File: rtl/dac_cal_timer.sv
module dac_cal_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en && (cnt != '1))
            cnt <= cnt + 1'b1;
    end

    // R6
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(cnt));

endmodule

// File: rtl/dac_cal_accum.sv
module dac_cal_accum #(
    parameter int W         = 24,
    parameter int RUNS_LOG2 = 2,
    parameter bit SIGNED    = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] din,
    output logic [W-1:0] avg
);

    localparam int SW   = W + RUNS_LOG2;
    localparam int RUNS = 1 << RUNS_LOG2;
    localparam int NW   = RUNS_LOG2 + 1;

    logic [SW-1:0] sum_q;
    logic [SW-1:0] din_ext;
    logic [NW-1:0] n_q;

    generate
        if (SIGNED) begin : g_sext
            assign din_ext = SW'($signed(din));
            assign avg     = W'($signed(sum_q) >>> RUNS_LOG2);
        end else begin : g_zext
            assign din_ext = SW'(din);
            assign avg     = W'(sum_q >> RUNS_LOG2);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            n_q   <= '0;
        end else if (clr) begin
            sum_q <= '0;
            n_q   <= '0;
        end else if (add) begin
            sum_q <= sum_q + din_ext;
            n_q   <= n_q + 1'b1;
        end
    end

    // R9
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        add |-> (n_q < NW'(RUNS)));

endmodule

// File: rtl/dac_cal_seq.sv
module dac_cal_seq
    import dac_cal_pkg::*;
#(
    parameter int CLK_KHZ   = 50000,
    parameter int OSC_MS    = 25,
    parameter int CAL_MS    = 500,
    parameter int POLL_GAP  = 5000,
    parameter int RUNS_LOG2 = 2,
    parameter int DATA_W    = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_do_reset,
    input  logic              cfg_use_poll,
    input  logic              cfg_keep_out,
    output logic              rstpat_req,
    input  logic              rstpat_ack,
    output logic              reg_req,
    output logic              reg_we,
    output logic [1:0]        reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_ack,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              ready,
    output logic              busy,
    output logic              error
);

    localparam int OSC_CYC = CLK_KHZ * OSC_MS;
    localparam int TMO_CYC = CLK_KHZ * CAL_MS;
    localparam int TW      = $clog2(TMO_CYC + 1);
    localparam int RUNS    = 1 << RUNS_LOG2;
    localparam int RW      = (RUNS_LOG2 > 0) ? RUNS_LOG2 : 1;

    seq_state_e state_q, state_d;

    logic          ph_clr, ph_en, el_clr, el_en;
    logic [TW-1:0] ph_cnt, el_cnt;
    logic          acc_clr, ofs_add, gain_add;
    logic          run_clr, run_inc;
    logic [RW-1:0] run_q;
    logic          do_reset_q, use_poll_q, keep_out_q;
    logic          osc_ok_q;
    logic          accept;
    logic [DATA_W-1:0] ofs_avg, gain_avg;

    assign accept = start && ((state_q == ST_IDLE) || (state_q == ST_READY) ||
                              (state_q == ST_FAULT));

    dac_cal_timer #(.W(TW)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(ph_clr), .en(ph_en), .cnt(ph_cnt)
    );

    dac_cal_timer #(.W(TW)) u_elapsed (
        .clk(clk), .rst_n(rst_n), .clr(el_clr), .en(el_en), .cnt(el_cnt)
    );

    dac_cal_accum #(.W(DATA_W), .RUNS_LOG2(RUNS_LOG2), .SIGNED(1'b1)) u_ofs_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(ofs_add),
        .din(reg_rdata), .avg(ofs_avg)
    );

    dac_cal_accum #(.W(DATA_W), .RUNS_LOG2(RUNS_LOG2), .SIGNED(1'b0)) u_gain_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(gain_add),
        .din(reg_rdata), .avg(gain_avg)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // datapath registers: run counter, captured configuration, osc flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= '0;
            do_reset_q <= 1'b0;
            use_poll_q <= 1'b0;
            keep_out_q <= 1'b0;
            osc_ok_q   <= 1'b0;
        end else begin
            if (run_clr)
                run_q <= '0;
            else if (run_inc)
                run_q <= run_q + 1'b1;
            if (accept) begin
                do_reset_q <= cfg_do_reset;
                use_poll_q <= cfg_use_poll;
                keep_out_q <= cfg_keep_out;
                osc_ok_q   <= 1'b0;
            end else if (state_q == ST_OSC && state_d != ST_OSC) begin
                osc_ok_q   <= 1'b1;
            end
        end
    end

    // next state and sequencing strobes
    always_comb begin
        state_d  = state_q;
        ph_clr   = 1'b0;
        ph_en    = 1'b0;
        el_clr   = 1'b0;
        el_en    = 1'b0;
        acc_clr  = 1'b0;
        ofs_add  = 1'b0;
        gain_add = 1'b0;
        run_clr  = 1'b0;
        run_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_READY, ST_FAULT: begin
                if (start) begin
                    state_d = ST_OSC;
                    ph_clr  = 1'b1;
                    acc_clr = 1'b1;
                    run_clr = 1'b1;
                end
            end
            ST_OSC: begin
                ph_en = 1'b1;
                if (ph_cnt >= TW'(OSC_CYC - 1)) begin
                    ph_clr  = 1'b1;
                    state_d = do_reset_q ? ST_RSTPAT : ST_CMD_WR;
                end
            end
            ST_RSTPAT: begin
                if (rstpat_ack)
                    state_d = ST_CMD_WR;
            end
            ST_CMD_WR: begin
                if (reg_ack) begin
                    state_d = ST_GAP;
                    ph_clr  = 1'b1;
                    el_clr  = 1'b1;
                end
            end
            ST_GAP: begin
                ph_en = 1'b1;
                el_en = 1'b1;
                if (el_cnt >= TW'(TMO_CYC - 1))
                    state_d = use_poll_q ? ST_FAULT : ST_RD_OFS;
                else if (use_poll_q && (ph_cnt >= TW'(POLL_GAP - 1)))
                    state_d = ST_POLL_RD;
            end
            ST_POLL_RD: begin
                el_en = 1'b1;
                if (reg_ack) begin
                    if (reg_rdata[1:0] == MODE_NORMAL)
                        state_d = ST_RD_OFS;
                    else if (el_cnt >= TW'(TMO_CYC - 1))
                        state_d = ST_FAULT;
                    else begin
                        state_d = ST_GAP;
                        ph_clr  = 1'b1;
                    end
                end
            end
            ST_RD_OFS: begin
                if (reg_ack) begin
                    ofs_add = 1'b1;
                    state_d = ST_RD_GAIN;
                end
            end
            ST_RD_GAIN: begin
                if (reg_ack) begin
                    gain_add = 1'b1;
                    if (run_q == RW'(RUNS - 1))
                        state_d = ST_WR_OFS;
                    else begin
                        run_inc = 1'b1;
                        state_d = ST_CMD_WR;
                    end
                end
            end
            ST_WR_OFS: begin
                if (reg_ack)
                    state_d = ST_WR_GAIN;
            end
            ST_WR_GAIN: begin
                if (reg_ack)
                    state_d = ST_READY;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rstpat_req = 1'b0;
        reg_req    = 1'b0;
        reg_we     = 1'b0;
        reg_addr   = RA_CMD;
        reg_wdata  = '0;
        ready      = 1'b0;
        busy       = 1'b1;
        error      = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_READY:  begin busy = 1'b0; ready = 1'b1; end
            ST_FAULT:  begin busy = 1'b0; error = 1'b1; end
            ST_RSTPAT: rstpat_req = 1'b1;
            ST_CMD_WR: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_wdata = DATA_W'({keep_out_q, MODE_SELFCAL});
            end
            ST_POLL_RD: reg_req = 1'b1;
            ST_RD_OFS:  begin reg_req = 1'b1; reg_addr = RA_OFS; end
            ST_RD_GAIN: begin reg_req = 1'b1; reg_addr = RA_GAIN; end
            ST_WR_OFS: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = RA_OFS;
                reg_wdata = ofs_avg;
            end
            ST_WR_GAIN: begin
                reg_req   = 1'b1;
                reg_we    = 1'b1;
                reg_addr  = RA_GAIN;
                reg_wdata = gain_avg;
            end
            default: ;
        endcase
    end

    // R2
    osc_before_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req || rstpat_req) |-> osc_ok_q);

    // R3
    rstpat_then_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rstpat_req && rstpat_ack) |=> (reg_req && reg_we && reg_addr == RA_CMD));

    // R7
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> (error && !reg_req && !busy));

    // R10
    ready_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(reg_ack && reg_we && reg_addr == RA_GAIN));

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && state_q != ST_OSC) |=> (state_q != ST_OSC));

endmodule

// File: tb/dac_cal_seq_test.sv
module dac_cal_seq_test;

    localparam int CLK_KHZ = 1;
    localparam int OSC_MS  = 25;
    localparam int CAL_MS  = 500;
    localparam int PGAP    = 8;
    localparam int RLOG    = 2;
    localparam int DW      = 24;
    localparam int OSC_CYC = CLK_KHZ * OSC_MS;
    localparam int TMO_CYC = CLK_KHZ * CAL_MS;
    localparam int RUNS    = 1 << RLOG;
    localparam int LAT     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_m = 1'b0, inj_start = 1'b0, start;
    logic cfg_do_reset = 1'b0, cfg_use_poll = 1'b0, cfg_keep_out = 1'b0;
    logic rstpat_req, rstpat_ack = 1'b0;
    logic reg_req, reg_we, reg_ack = 1'b0;
    logic [1:0] reg_addr;
    logic [DW-1:0] reg_wdata, reg_rdata = '0;
    logic ready, busy, error;

    assign start = start_m | inj_start;

    dac_cal_seq #(
        .CLK_KHZ(CLK_KHZ), .OSC_MS(OSC_MS), .CAL_MS(CAL_MS),
        .POLL_GAP(PGAP), .RUNS_LOG2(RLOG), .DATA_W(DW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_do_reset(cfg_do_reset), .cfg_use_poll(cfg_use_poll),
        .cfg_keep_out(cfg_keep_out),
        .rstpat_req(rstpat_req), .rstpat_ack(rstpat_ack),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .ready(ready), .busy(busy), .error(error)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit            we;
        bit [1:0]      addr;
        bit [DW-1:0]   data;
        string         tag;
    } item_t;

    item_t exp_q[$];

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    int k_arr[RUNS];
    int ofs_arr[RUNS];
    int gain_arr[RUNS];

    bit poll_forever = 1'b0, poll_mode = 1'b0, inject = 1'b0;
    bit seen_req = 1'b0, gap_armed = 1'b0;
    int run_idx = 0, polls_left = 0, rstpat_cnt = 0;
    int start_cyc = 0, first_req_cyc = 0, cmd_ack_cyc = 0, end_cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // register slave and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (reg_req) begin
                if (!seen_req) begin
                    seen_req      = 1'b1;
                    first_req_cyc = cyc;
                end
                if (gap_armed && reg_addr == 2'd1) begin
                    gap_armed = 1'b0;
                    chk(cyc - cmd_ack_cyc >= TMO_CYC, "R6 timed wait", cyc - cmd_ack_cyc, TMO_CYC);
                end
                repeat (LAT) @(negedge clk);
                case (reg_addr)
                    2'd0: begin
                        if (poll_forever) reg_rdata = 24'h000001;
                        else if (polls_left > 0) begin
                            reg_rdata = 24'h000001;
                            polls_left--;
                        end else reg_rdata = 24'h000000;
                    end
                    2'd1: reg_rdata = DW'(ofs_arr[run_idx]);
                    default: reg_rdata = DW'(gain_arr[run_idx]);
                endcase
                reg_ack = 1'b1;
                if (exp_q.size() == 0) begin
                    if (!(poll_forever && !reg_we && reg_addr == 2'd0))
                        chk(1'b0, "R8 unexpected access", {reg_we, reg_addr}, 0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(reg_we == e.we && reg_addr == e.addr, e.tag,
                        {reg_we, reg_addr}, {e.we, e.addr});
                    if (e.we)
                        chk(reg_wdata == e.data, e.tag, reg_wdata, e.data);
                end
                if (reg_we && reg_addr == 2'd0) begin
                    cmd_ack_cyc = cyc;
                    gap_armed   = !poll_mode;
                    polls_left  = k_arr[run_idx];
                end
                if (reg_we && reg_addr == 2'd2)
                    chk(!ready && busy, "R10 ready before final write", ready, 0);
                if (inject && !reg_we && reg_addr == 2'd1 && run_idx == 1) begin
                    inj_start = 1'b1;
                    inject    = 1'b0;
                end
                if (!reg_we && reg_addr == 2'd2) run_idx++;
                @(negedge clk);
                reg_ack   = 1'b0;
                inj_start = 1'b0;
            end
        end
    end

    // reset pattern driver model
    initial begin
        forever begin
            @(negedge clk);
            if (rstpat_req) begin
                rstpat_cnt++;
                chk(!seen_req, "R3 pattern before register access", seen_req, 0);
                chk(cyc - start_cyc >= OSC_CYC, "R2 pattern after osc wait", cyc - start_cyc, OSC_CYC);
                repeat (3) @(negedge clk);
                chk(rstpat_req, "R3 pattern request held", rstpat_req, 1);
                rstpat_ack = 1'b1;
                @(negedge clk);
                rstpat_ack = 1'b0;
            end
        end
    end

    // driver: pushes expected transactions and starts the sequence
    task automatic run_seq(input bit poll, input bit dorst, input bit keep, input bit forever_busy);
        int s;
        longint g;
        cfg_use_poll = poll;
        cfg_do_reset = dorst;
        cfg_keep_out = keep;
        poll_mode    = poll;
        poll_forever = forever_busy;
        run_idx      = 0;
        seen_req     = 1'b0;
        rstpat_cnt   = 0;
        gap_armed    = 1'b0;
        s = 0;
        g = 0;
        for (int r = 0; r < RUNS; r++) begin
            exp_q.push_back('{1'b1, 2'd0, DW'({keep, 2'b01}), "R4 command write"});
            if (forever_busy) break;
            if (poll)
                for (int i = 0; i <= k_arr[r]; i++)
                    exp_q.push_back('{1'b0, 2'd0, '0, "R5 poll read"});
            exp_q.push_back('{1'b0, 2'd1, '0, "R8 offset read"});
            exp_q.push_back('{1'b0, 2'd2, '0, "R8 full-scale read"});
            s += ofs_arr[r];
            g += longint'(gain_arr[r]);
        end
        if (!forever_busy) begin
            exp_q.push_back('{1'b1, 2'd1, DW'(s >>> RLOG), "R9 offset average"});
            exp_q.push_back('{1'b1, 2'd2, DW'(g >> RLOG), "R9 full-scale average"});
        end
        @(negedge clk);
        start_m   = 1'b1;
        start_cyc = cyc;
        @(negedge clk);
        start_m = 1'b0;
        chk(busy && !ready && !error, "R10 busy after start", {busy, ready, error}, 3'b100);
        while (busy) @(negedge clk);
        end_cyc = cyc;
        chk(exp_q.size() == 0, "R8 all transactions seen", exp_q.size(), 0);
        chk(rstpat_cnt == int'(dorst), "R3 pattern count", rstpat_cnt, int'(dorst));
        chk(first_req_cyc - start_cyc >= OSC_CYC, "R2 osc wait", first_req_cyc - start_cyc, OSC_CYC);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({ready, busy, error, reg_req, rstpat_req} == 5'b0, "R1 reset outputs",
            {ready, busy, error, reg_req, rstpat_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({ready, busy, error, reg_req, rstpat_req} == 5'b0, "R1 idle after reset",
            {ready, busy, error, reg_req, rstpat_req}, 0);

        // polled, with reset pattern, output kept; start injected mid-run (R11)
        k_arr    = '{1, 3, 0, 2};
        ofs_arr  = '{-5, -6, -3, 3};
        gain_arr = '{24'h80000A, 24'h80000D, 24'h800007, 24'h800015};
        inject   = 1'b1;
        run_seq(1'b1, 1'b1, 1'b1, 1'b0);
        chk(ready && !error, "R10 ready after polled run", {ready, error}, 2'b10);
        chk(inject == 1'b0, "R11 start injected while busy", inject, 0);
        repeat (20) @(negedge clk);
        chk(ready && !busy && !reg_req, "R10 ready holds", {ready, busy, reg_req}, 3'b100);

        // polled, converter never finishes: timeout fault
        run_seq(1'b1, 1'b0, 1'b0, 1'b1);
        chk(error && !ready, "R7 fault flag", {error, ready}, 2'b10);
        chk(end_cyc - cmd_ack_cyc >= TMO_CYC, "R7 fault not before limit", end_cyc - cmd_ack_cyc, TMO_CYC);
        begin
            bit any_req = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (reg_req || rstpat_req) any_req = 1'b1;
            end
            chk(!any_req && error, "R7 quiet after fault", any_req, 0);
        end
        poll_forever = 1'b0;

        // timed mode, no reset pattern, output disconnected; large full-scale values
        k_arr    = '{0, 0, 0, 0};
        ofs_arr  = '{100, 7, -1, 0};
        gain_arr = '{24'hFFFFFF, 24'hFFFFFE, 24'h000003, 24'h7FFFFF};
        run_seq(1'b0, 1'b0, 1'b0, 1'b0);
        chk(ready && !error, "R10 ready after timed run, fault cleared", {ready, error}, 2'b10);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule